// File: doc/BRIEF.md
# Programming Mode Entry Detector

This block decides whether a device should leave normal operation and enter a programming mode, and which of the two entry paths was used. It watches five digitized pin levels: the reset pin at a logic-high level, the reset pin at an elevated programming voltage, a dedicated low-voltage enable pin, and the serial clock and data pins. It also reads a stored configuration bit that permits the low-voltage path. Every pin level is resynchronized to the local clock before any sequence logic looks at it.

The low-voltage path needs all four control lines to start low. The enable pin must then rise, followed by the reset pin rising to the normal logic level, and the stored permission bit must be set. The high-voltage path needs the clock, data and reset lines low, followed by the elevated voltage on the reset pin. It ignores the enable pin and the stored bit. A request to clear the stored permission bit is honoured only while the high-voltage mode is active, so the low-voltage path can only be switched off from the other path. Programming ends when the reset pin drops low, and every new entry must repeat its whole sequence.

Top module: `prog_entry_detector`

## Requirements
- R1: While `rst_n` is low, `prog_active` is 0, `prog_mode` is 2'b00 and `cfg_lv_clr` is 0.
- R2: With the clock, data, enable and reset pins all low, a rise of the enable pin followed by a rise of `rst_pin_high` while `cfg_lv_allow` is 1 sets `prog_active` to 1 and `prog_mode` to 2'b01 (low-voltage).
- R3: The low-voltage sequence of R2 leaves the block in normal mode (`prog_mode` 2'b00) when `cfg_lv_allow` is 0.
- R4: An enable-pin rise while the reset pin is already high leaves the block in normal mode.
- R5: If the enable pin is already high when the other lines go low, a later reset-pin rise does not enter the low-voltage mode.
- R6: With the clock, data and reset pins low, a rise of `rst_pin_hv` sets `prog_mode` to 2'b10 (high-voltage), whatever the levels of the enable pin and `cfg_lv_allow`. The block never moves directly between 2'b01 and 2'b10.
- R7: A high clock or data pin when the reset pin or the elevated voltage rises blocks both entry paths.
- R8: When both `rst_pin_high` and `rst_pin_hv` return low, the block returns to normal mode. A new entry requires the full sequence again. `prog_active` is 1 exactly when `prog_mode` is not 2'b00.
- R9: `clr_lv_req` high during a clock cycle in high-voltage mode gives a one-cycle pulse on `cfg_lv_clr` in the next cycle. In any other mode the request is ignored and `cfg_lv_clr` stays 0.
- R10: Each pin passes through `SYNC_STAGES` (default 2) flops. A pin change driven before clock edge k shows on the mode outputs after edge k+SYNC_STAGES, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_pin_high | input | 1 | Reset pin seen at normal logic-high level |
| rst_pin_hv | input | 1 | Reset pin seen at elevated programming voltage |
| lv_en_pin | input | 1 | Low-voltage entry enable pin |
| pgm_clk_pin | input | 1 | Serial programming clock pin |
| pgm_dat_pin | input | 1 | Serial programming data pin |
| cfg_lv_allow | input | 1 | Stored configuration bit permitting low-voltage entry |
| clr_lv_req | input | 1 | Request to clear the stored permission bit |
| prog_active | output | 1 | High while in either programming mode |
| prog_mode | output | 2 | 00 normal, 01 low-voltage, 10 high-voltage |
| cfg_lv_clr | output | 1 | Write strobe that clears the stored permission bit |

## Verification
On every cycle the assertions check that the mode code stays legal and agrees with the active flag. They check that the block never jumps between the two programming modes, that a low-voltage entry is always preceded by a set permission bit, and that the clear strobe appears exactly when a request arrived during high-voltage mode. The ordering rules can only be shown by the bench scenarios, which drive pin sequences against a behavioural model: enable before reset, lines low at the start, a blocking clock or data level, and re-entry after exit. The same scenarios cover the synchronizer latency.

// File: rtl/pme_pkg.sv
package pme_pkg;

   // bit positions inside the packed pin vector
   localparam int PIN_HI    = 0;
   localparam int PIN_HV    = 1;
   localparam int PIN_EN    = 2;
   localparam int PIN_CLK   = 3;
   localparam int PIN_DAT   = 4;
   localparam int PIN_COUNT = 5;

   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,  // normal operation
      ST_QUIET    = 3'd1,  // all lines low, enable low
      ST_QUIET_EN = 3'd2,  // lines low but enable already high
      ST_ARMED    = 3'd3,  // enable rose after a clean quiet start
      ST_PROG_LV  = 3'd4,
      ST_PROG_HV  = 3'd5
   } pme_state_e;

   typedef enum logic [1:0] {
      MODE_NONE = 2'b00,
      MODE_LV   = 2'b01,
      MODE_HV   = 2'b10
   } pme_mode_e;

endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/pme_seq.sv
module pme_seq
   import pme_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] pins,
   input  logic                 lv_allow,
   output pme_state_e           state,
   output logic [1:0]           mode,
   output logic                 active
);

   logic hi, hv, en, lines_low, all_low;
   pme_state_e nxt;

   assign hi        = pins[PIN_HI];
   assign hv        = pins[PIN_HV];
   assign en        = pins[PIN_EN];
   assign lines_low = !pins[PIN_CLK] && !pins[PIN_DAT];
   assign all_low   = lines_low && !hi && !hv;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN: begin
            if (all_low) nxt = en ? ST_QUIET_EN : ST_QUIET;
         end
         ST_QUIET: begin
            if (hv && lines_low)      nxt = ST_PROG_HV;
            else if (hi || !lines_low) nxt = ST_RUN;
            else if (en)              nxt = ST_ARMED;
         end
         ST_QUIET_EN: begin
            if (hv && lines_low)      nxt = ST_PROG_HV;
            else if (hi || !lines_low) nxt = ST_RUN;
            else if (!en)             nxt = ST_QUIET;
         end
         ST_ARMED: begin
            if (hv && lines_low)  nxt = ST_PROG_HV;
            else if (!lines_low)  nxt = ST_RUN;
            else if (hi)          nxt = (lv_allow && en) ? ST_PROG_LV : ST_RUN;
            else if (!en)         nxt = ST_QUIET;
         end
         ST_PROG_LV, ST_PROG_HV: begin
            if (!hi && !hv) nxt = ST_RUN;
         end
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RUN;
      else        state <= nxt;
   end

   always_comb begin
      unique case (state)
         ST_PROG_LV: mode = MODE_LV;
         ST_PROG_HV: mode = MODE_HV;
         default:    mode = MODE_NONE;
      endcase
   end

   assign active = (state == ST_PROG_LV) || (state == ST_PROG_HV);

endmodule

// File: rtl/pme_clr_gate.sv
module pme_clr_gate
   import pme_pkg::*;
#(
   parameter bit REGISTERED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pme_state_e state,
   input  logic       req,
   output logic       clr
);

   logic grant;
   assign grant = req && (state == ST_PROG_HV);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clr <= 1'b0;
         else        clr <= grant;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign clr = grant;
   end

endmodule

// File: rtl/prog_entry_detector.sv
module prog_entry_detector
   import pme_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit CLR_REGISTERED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_pin_high,
   input  logic       rst_pin_hv,
   input  logic       lv_en_pin,
   input  logic       pgm_clk_pin,
   input  logic       pgm_dat_pin,
   input  logic       cfg_lv_allow,
   input  logic       clr_lv_req,
   output logic       prog_active,
   output logic [1:0] prog_mode,
   output logic       cfg_lv_clr
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PIN_COUNT-1:0] raw_pins, sync_pins;
   pme_state_e           state;

   always_comb begin
      raw_pins          = '0;
      raw_pins[PIN_HI]  = rst_pin_high;
      raw_pins[PIN_HV]  = rst_pin_hv;
      raw_pins[PIN_EN]  = lv_en_pin;
      raw_pins[PIN_CLK] = pgm_clk_pin;
      raw_pins[PIN_DAT] = pgm_dat_pin;
   end

   pme_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_pins),
      .dout (sync_pins)
   );

   pme_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (sync_pins),
      .lv_allow(cfg_lv_allow),
      .state   (state),
      .mode    (prog_mode),
      .active  (prog_active)
   );

   pme_clr_gate #(.REGISTERED(CLR_REGISTERED)) u_clr (
      .clk  (clk),
      .rst_n(rst_n),
      .state(state),
      .req  (clr_lv_req),
      .clr  (cfg_lv_clr)
   );

endmodule

// File: rtl/pme_checker.sv
module pme_checker #(
   parameter bit CLR_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_lv_allow,
   input logic       clr_lv_req,
   input logic       prog_active,
   input logic [1:0] prog_mode,
   input logic       cfg_lv_clr
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (!prog_active && prog_mode == 2'b00 && !cfg_lv_clr);
      end
   end

   assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode != 2'b11);

   assert_active_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_active == (prog_mode != 2'b00));

   assert_lv_needs_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_mode == 2'b01) |-> $past(cfg_lv_allow));

   assert_no_lv_to_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_mode == 2'b01) |=> (prog_mode != 2'b10));

   assert_no_hv_to_lv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_mode == 2'b10) |=> (prog_mode != 2'b01));

   if (CLR_REG) begin : g_reg
      assert_clr_only_hv_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_lv_clr |-> ($past(prog_mode) == 2'b10 && $past(clr_lv_req)));
      assert_clr_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (prog_mode == 2'b10 && clr_lv_req) |=> cfg_lv_clr);
   end else begin : g_comb
      assert_clr_only_hv_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_lv_clr |-> (prog_mode == 2'b10 && clr_lv_req));
   end

endmodule

bind prog_entry_detector pme_checker #(.CLR_REG(CLR_REGISTERED)) u_pme_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_lv_allow(cfg_lv_allow),
   .clr_lv_req  (clr_lv_req),
   .prog_active (prog_active),
   .prog_mode   (prog_mode),
   .cfg_lv_clr  (cfg_lv_clr)
);

// File: tb/tb_prog_entry_detector.sv
`timescale 1ns/1ps
module tb_prog_entry_detector;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic p_hi = 0, p_hv = 0, p_en = 0, p_ck = 0, p_dt = 0;
   logic cfg = 1'b1, clr = 1'b0;
   logic       act, lvclr;
   logic [1:0] mode;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   prog_entry_detector dut (
      .clk(clk), .rst_n(rst_n),
      .rst_pin_high(p_hi), .rst_pin_hv(p_hv), .lv_en_pin(p_en),
      .pgm_clk_pin(p_ck), .pgm_dat_pin(p_dt),
      .cfg_lv_allow(cfg), .clr_lv_req(clr),
      .prog_active(act), .prog_mode(mode), .cfg_lv_clr(lvclr)
   );

   // behavioural reference: 0 run,1 quiet,2 quiet+en,3 armed,4 lv,5 hv
   logic [4:0] pq[$];
   int  m_st = 0;
   bit  m_clr = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pq = {5'd0, 5'd0};
         m_st = 0;
         m_clr = 0;
      end else begin
         logic [4:0] d;
         bit hi, hv, en, low, quiet;
         d = pq.pop_front();
         pq.push_back({p_dt, p_ck, p_en, p_hv, p_hi});
         hi = d[0]; hv = d[1]; en = d[2];
         low = !d[3] && !d[4];
         quiet = low && !hi && !hv;
         m_clr = (m_st == 5) && clr;
         if (m_st == 0) begin
            if (quiet) m_st = en ? 2 : 1;
         end else if (m_st >= 1 && m_st <= 3) begin
            if (hv && low) m_st = 5;
            else if (!low) m_st = 0;
            else if (hi) m_st = (m_st == 3 && cfg && en) ? 4 : 0;
            else if (m_st == 1 && en) m_st = 3;
            else if (m_st != 1 && !en) m_st = 1;
         end else begin
            if (!hi && !hv) m_st = 0;
         end
      end
   end

   always @(negedge clk) begin
      logic [1:0] em;
      em = (m_st == 4) ? 2'b01 : (m_st == 5) ? 2'b10 : 2'b00;
      checks++;
      if (act !== (m_st >= 4) || mode !== em || lvclr !== m_clr) begin
         fails++;
         $display("FAIL model compare: actual act=%b mode=%b clr=%b expected act=%b mode=%b clr=%b",
                  act, mode, lvclr, (m_st >= 4), em, m_clr);
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_mode(string tag, logic [1:0] exp);
      checks++;
      if (mode !== exp || act !== (exp != 2'b00)) begin
         fails++;
         $display("FAIL %s: actual mode=%b act=%b expected mode=%b", tag, mode, act, exp);
      end
   endtask

   task automatic expect_clr(string tag, logic exp);
      checks++;
      if (lvclr !== exp) begin
         fails++;
         $display("FAIL %s: actual cfg_lv_clr=%b expected %b", tag, lvclr, exp);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      wait_n(3);
      expect_mode("R1 reset mode", 2'b00);
      expect_clr("R1 reset strobe", 1'b0);
      rst_n = 1'b1;
      wait_n(4);

      // low-voltage entry
      p_en = 1; wait_n(4);
      p_hi = 1; wait_n(2);
      expect_mode("R10 not before sync delay", 2'b00);
      wait_n(1);
      expect_mode("R2 low-voltage entry", 2'b01);

      // clear ignored in low-voltage mode
      clr = 1; wait_n(1); clr = 0;
      expect_clr("R9 clear ignored in LV", 1'b0);
      wait_n(1);
      expect_clr("R9 clear ignored in LV later", 1'b0);

      // exit with enable held high, then no re-entry
      p_hi = 0; wait_n(3);
      expect_mode("R8 exit on reset low", 2'b00);
      p_hi = 1; wait_n(4);
      expect_mode("R5 enable high at start blocks", 2'b00);
      expect_mode("R8 re-entry needs full sequence", 2'b00);

      // enable after reset high
      p_en = 0; wait_n(4);
      p_en = 1; wait_n(4);
      expect_mode("R4 enable after reset", 2'b00);

      // permission bit clear
      cfg = 0; p_hi = 0; p_en = 0; wait_n(4);
      p_en = 1; wait_n(4);
      p_hi = 1; wait_n(4);
      expect_mode("R3 blocked by cfg bit", 2'b00);
      cfg = 1;

      // high-voltage entry with enable high and cfg set
      p_hi = 0; wait_n(4);
      p_hv = 1; p_hi = 1; wait_n(2);
      expect_mode("R10 HV not before sync delay", 2'b00);
      wait_n(1);
      expect_mode("R6 high-voltage entry", 2'b10);

      clr = 1; wait_n(1); clr = 0;
      expect_clr("R9 clear pulse in HV", 1'b1);
      wait_n(1);
      expect_clr("R9 clear pulse one cycle", 1'b0);

      p_hv = 0; p_hi = 0; wait_n(3);
      expect_mode("R8 exit from HV", 2'b00);

      // clock or data high blocks entry
      p_en = 0; wait_n(4);
      p_ck = 1; wait_n(4);
      p_hv = 1; p_hi = 1; wait_n(4);
      expect_mode("R7 clock high blocks HV", 2'b00);
      p_hv = 0; p_hi = 0; p_ck = 0; wait_n(4);
      p_dt = 1; p_en = 1; wait_n(4);
      p_hi = 1; wait_n(4);
      expect_mode("R7 data high blocks LV", 2'b00);
      p_dt = 0; p_en = 0; wait_n(4);

      clr = 1; wait_n(1); clr = 0;
      expect_clr("R9 clear ignored in run", 1'b0);

      // clean second low-voltage entry
      p_hi = 0; wait_n(4);
      p_en = 1; wait_n(4);
      p_hi = 1; wait_n(3);
      expect_mode("R2 second LV entry", 2'b01);
      wait_n(4);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule